// File: doc/BRIEF.md
# Configuration transaction controller

This block gives software a three-word command window for reading and changing board configuration values: oscillator frequency settings for the main board and a daughter board, and read-only voltage readings. Software first loads an argument into the data word. It then writes a packed command word to the control word with the go bit set. The command is decoded and checked in the same clock edge that accepts it. If the target is valid, the access runs against an internal table, and a read result is copied into the data word. The status word then shows that the command finished, and whether it failed.

A few command codes do not touch the table. A write with the power-off code or the restart code produces a one-cycle request pulse on its own output. Two further codes, for video routing and display mode, are accepted and do nothing. Reads come back one cycle after the read strobe, together with a valid flag.

Top module: `cfg_txn_top`

## Requirements
- R1: After reset, the data, control and status words read 0. Main board oscillator entries 0 to 5 hold 50000000, 23750000, 24000000, 24000000, 24000000 and 24000000. Daughter board oscillator entries hold their parameter values.
- R2: The control word (offset 0xA4) stores the written value, except that bit 31 (go) and bits 19:18 always read as 0. The command fields are: bit 30 write (1) or read (0), bits 29:26 channel, bits 25:20 function, bits 17:16 site, bits 15:12 position, bits 11:0 device.
- R3: A control write with bit 31 set makes the status word (offset 0xA8) read 1, replacing its previous value, with bit 1 set on failure. A control write with bit 31 clear leaves the status unchanged.
- R4: A command fails unless channel is 0, position is 0 and site is 0 (main board) or 1 (daughter board). A failed command changes neither the data word nor the table.
- R5: Function 1 (oscillator) with site 0 reads main board entry `device` when device is below 6. Device 6 or above fails.
- R6: A function 1 write copies the data word (offset 0xA0) into the addressed entry. For site 1 this works for any device below the daughter board entry count, and fails at or above it.
- R7: Function 2 (voltage) is read-only. Site 0, device 0 returns 3300000. Site 1 with a device below the sensor count returns that sensor's parameter value. Any other voltage target, and any voltage write, fails.
- R8: A successful read command loads its result into the data word. A failed read leaves the data word unchanged.
- R9: A write command with function 8 (site 0, device 0) pulses `shutdownReq` high for exactly one cycle. Function 9 does the same on `rebootReq`. A read command, or another device, fails and produces no pulse.
- R10: Write commands with function 7 or 11 at site 0, device 0 complete without error and have no other effect. Any other function code, or a read of these functions, fails.
- R11: A write to the status word stores only bits 1:0 of the written value.
- R12: Reads of any offset other than 0xA0, 0xA4 and 0xA8 return 0. Writes to such offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data |
| rdData | output | 32 | Read data, valid one cycle after rdEn |
| rdValid | output | 1 | Marks rdData as valid |
| shutdownReq | output | 1 | One-cycle power-off request |
| rebootReq | output | 1 | One-cycle restart request |

## Verification
The bench targets these cases:
- The first invalid device on each site (6 on the main board, the entry count on the daughter board). An off-by-one decoder would either fail a legal entry or alias into the wrong table slot.
- Each of channel, position and site made illegal on its own. A design that checks only one of them would report success and overwrite the data word.
- Failed reads, to confirm the data word is kept. A design that captures on every command would corrupt it.
- Voltage writes, and reads of the request codes, which must fail. A design that decodes the function code without the direction would pulse a request or accept the command.
- Status writes with upper bits set, and a control write without the go bit, which catch leaky masking and spurious completion.

// File: rtl/cfg_txn_pkg.sv
package cfg_txn_pkg;
  localparam int WORD_W     = 32;
  localparam int TBL_IDX_W  = 8;
  localparam int MB_CLKS    = 6;
  localparam logic [WORD_W-1:0] MB_VOLT_UV = 32'd3300000;

  localparam int GO_BIT     = 31;
  localparam int DIR_BIT    = 30;
  localparam logic [WORD_W-1:0] CTRL_KEEP = 32'h7FF3_FFFF;

  localparam logic [5:0] FN_OSC     = 6'd1;
  localparam logic [5:0] FN_VOLT    = 6'd2;
  localparam logic [5:0] FN_VIDMUX  = 6'd7;
  localparam logic [5:0] FN_OFF     = 6'd8;
  localparam logic [5:0] FN_RESTART = 6'd9;
  localparam logic [5:0] FN_DISP    = 6'd11;

  localparam logic [1:0] SITE_MAIN     = 2'd0;
  localparam logic [1:0] SITE_DAUGHTER = 2'd1;

  typedef struct packed {
    logic                 exec;
    logic                 fail;
    logic                 tblWr;
    logic                 capture;
    logic                 fromVolt;
    logic [TBL_IDX_W-1:0] idx;
    logic                 offReq;
    logic                 restartReq;
  } txnStrobe_t;

  function automatic logic [WORD_W-1:0] mbClkInit(input int i);
    case (i)
      0:       mbClkInit = 32'd50000000;
      1:       mbClkInit = 32'd23750000;
      default: mbClkInit = 32'd24000000;
    endcase
  endfunction
endpackage

// File: rtl/cfg_txn_ctrl.sv
module cfg_txn_ctrl
  import cfg_txn_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DB_CLKS  = 2,
  parameter int DB_VOLTS = 2,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hA4
) (
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output txnStrobe_t        stb
);
  logic        go;
  logic        isWr;
  logic [3:0]  chan;
  logic [5:0]  fn;
  logic [1:0]  site;
  logic [3:0]  pos;
  logic [11:0] dev;
  logic        legalTarget;
  logic        ok;
  logic        unusedBits;

  assign go          = wrEn && (addr == CTRL_OFS) && wdata[GO_BIT];
  assign isWr        = wdata[DIR_BIT];
  assign chan        = wdata[29:26];
  assign fn          = wdata[25:20];
  assign site        = wdata[17:16];
  assign pos         = wdata[15:12];
  assign dev         = wdata[11:0];
  assign unusedBits  = ^wdata[19:18];
  assign legalTarget = (chan == 4'd0) && (pos == 4'd0) &&
                       ((site == SITE_MAIN) || (site == SITE_DAUGHTER));

  always_comb begin
    stb = '0;
    ok  = 1'b0;
    if (go && legalTarget) begin
      case (fn)
        FN_OSC: begin
          if (site == SITE_MAIN && int'(dev) < MB_CLKS) begin
            ok      = 1'b1;
            stb.idx = TBL_IDX_W'(dev);
          end else if (site == SITE_DAUGHTER && int'(dev) < DB_CLKS) begin
            ok      = 1'b1;
            stb.idx = TBL_IDX_W'(MB_CLKS) + TBL_IDX_W'(dev);
          end
          stb.tblWr   = ok && isWr;
          stb.capture = ok && !isWr;
        end
        FN_VOLT: begin
          if (!isWr && site == SITE_MAIN && dev == 12'd0) begin
            ok      = 1'b1;
            stb.idx = '0;
          end else if (!isWr && site == SITE_DAUGHTER && int'(dev) < DB_VOLTS) begin
            ok      = 1'b1;
            stb.idx = TBL_IDX_W'(1) + TBL_IDX_W'(dev);
          end
          stb.fromVolt = ok;
          stb.capture  = ok;
        end
        FN_VIDMUX, FN_DISP: begin
          ok = isWr && site == SITE_MAIN && dev == 12'd0;
        end
        FN_OFF: begin
          ok         = isWr && site == SITE_MAIN && dev == 12'd0;
          stb.offReq = ok;
        end
        FN_RESTART: begin
          ok             = isWr && site == SITE_MAIN && dev == 12'd0;
          stb.restartReq = ok;
        end
        default: ok = 1'b0;
      endcase
    end
    stb.exec = go;
    stb.fail = go && !ok;
  end
endmodule

// File: rtl/cfg_txn_dpath.sv
module cfg_txn_dpath
  import cfg_txn_pkg::*;
#(
  parameter int DB_CLKS  = 2,
  parameter int DB_VOLTS = 2,
  parameter logic [DB_CLKS*32-1:0]  DB_CLK_INIT  = {32'd30000000, 32'd25000000},
  parameter logic [DB_VOLTS*32-1:0] DB_VOLT_INIT = {32'd1000000, 32'd900000}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              dataWr,
  input  logic              ctrlWr,
  input  logic              statWr,
  input  logic [WORD_W-1:0] wdata,
  input  txnStrobe_t        stb,
  output logic [WORD_W-1:0] dataQ,
  output logic [WORD_W-1:0] ctrlQ,
  output logic [1:0]        statQ,
  output logic              offPulse,
  output logic              restartPulse
);
  localparam int TBL_N = MB_CLKS + DB_CLKS;

  logic [WORD_W-1:0] clkTbl [TBL_N];
  logic [WORD_W-1:0] oscVal;
  logic [WORD_W-1:0] voltVal;
  logic [WORD_W-1:0] fetched;

  for (genvar e = 0; e < TBL_N; e++) begin : g_entry
    localparam logic [WORD_W-1:0] INIT =
      (e < MB_CLKS) ? mbClkInit(e) : DB_CLK_INIT[(e-MB_CLKS)*32 +: 32];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        clkTbl[e] <= INIT;
      else if (stb.tblWr && stb.idx == TBL_IDX_W'(e))
        clkTbl[e] <= dataQ;
    end
  end

  always_comb begin
    oscVal = '0;
    for (int i = 0; i < TBL_N; i++)
      if (stb.idx == TBL_IDX_W'(i)) oscVal = clkTbl[i];
  end

  always_comb begin
    voltVal = MB_VOLT_UV;
    for (int j = 0; j < DB_VOLTS; j++)
      if (stb.idx == TBL_IDX_W'(j + 1)) voltVal = DB_VOLT_INIT[j*32 +: 32];
  end

  assign fetched = stb.fromVolt ? voltVal : oscVal;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ        <= '0;
      ctrlQ        <= '0;
      statQ        <= '0;
      offPulse     <= 1'b0;
      restartPulse <= 1'b0;
    end else begin
      offPulse     <= stb.offReq;
      restartPulse <= stb.restartReq;
      if (dataWr)      dataQ <= wdata;
      if (ctrlWr)      ctrlQ <= wdata & CTRL_KEEP;
      if (statWr)      statQ <= wdata[1:0];
      if (stb.exec) begin
        statQ <= {stb.fail, 1'b1};
        if (stb.capture) dataQ <= fetched;
      end
    end
  end
endmodule

// File: rtl/cfg_txn_top.sv
module cfg_txn_top
  import cfg_txn_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DB_CLKS  = 2,
  parameter int DB_VOLTS = 2,
  parameter logic [DB_CLKS*32-1:0]  DB_CLK_INIT  = {32'd30000000, 32'd25000000},
  parameter logic [DB_VOLTS*32-1:0] DB_VOLT_INIT = {32'd1000000, 32'd900000},
  parameter logic [ADDR_W-1:0] DATA_OFS = 8'hA0,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hA4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'hA8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdData,
  output logic              rdValid,
  output logic              shutdownReq,
  output logic              rebootReq
);
  txnStrobe_t        stb;
  logic [WORD_W-1:0] dataQ;
  logic [WORD_W-1:0] ctrlQ;
  logic [1:0]        statQ;

  cfg_txn_ctrl #(
    .ADDR_W(ADDR_W), .DB_CLKS(DB_CLKS), .DB_VOLTS(DB_VOLTS), .CTRL_OFS(CTRL_OFS)
  ) u_ctrl (
    .wrEn(wrEn), .addr(addr), .wdata(wdata), .stb(stb)
  );

  cfg_txn_dpath #(
    .DB_CLKS(DB_CLKS), .DB_VOLTS(DB_VOLTS),
    .DB_CLK_INIT(DB_CLK_INIT), .DB_VOLT_INIT(DB_VOLT_INIT)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .dataWr(wrEn && addr == DATA_OFS),
    .ctrlWr(wrEn && addr == CTRL_OFS),
    .statWr(wrEn && addr == STAT_OFS),
    .wdata(wdata), .stb(stb),
    .dataQ(dataQ), .ctrlQ(ctrlQ), .statQ(statQ),
    .offPulse(shutdownReq), .restartPulse(rebootReq)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else begin
      rdValid <= rdEn;
      if (rdEn) begin
        if (addr == DATA_OFS)      rdData <= dataQ;
        else if (addr == CTRL_OFS) rdData <= ctrlQ;
        else if (addr == STAT_OFS) rdData <= {30'd0, statQ};
        else                       rdData <= '0;
      end
    end
  end
endmodule

// File: rtl/cfg_txn_chk.sv
module cfg_txn_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 8'hA4,
  parameter logic [ADDR_W-1:0] STAT_OFS = 8'hA8
) (
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       ctrlQ,
  input logic [1:0]        statQ,
  input logic              shutdownReq,
  input logic              rebootReq
);
  logic goWr;
  assign goWr = wrEn && addr == CTRL_OFS && wdata[31];

  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrlQ[31] == 1'b0 && ctrlQ[19:18] == 2'b00);

  // R3
  go_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    goWr |=> statQ[0]);

  // R4
  bad_chan_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goWr && wdata[29:26] != 4'd0) |=> statQ == 2'b11);

  // R9
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({shutdownReq, rebootReq}));

  // R9
  off_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(goWr && wdata[30] && wdata[25:20] == 6'd8));

  // R11
  stat_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == STAT_OFS) |=> statQ == $past(wdata[1:0]));
endmodule

bind cfg_txn_top cfg_txn_chk #(
  .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .STAT_OFS(STAT_OFS)
) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wdata(wdata),
  .ctrlQ(ctrlQ), .statQ(statQ), .shutdownReq(shutdownReq), .rebootReq(rebootReq)
);

// File: tb/tb_cfg_txn_top.sv
`timescale 1ns/1ps
module tb_cfg_txn_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdData;
  logic        rdValid;
  logic        shutdownReq;
  logic        rebootReq;

  int vectors = 0;
  int miscompares = 0;
  int shutCnt = 0;
  int rebootCnt = 0;
  bit done = 0;

  logic [31:0] expQ [$];
  string       tagQ [$];

  always #2.5 clk = ~clk;

  cfg_txn_top dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wdata(wdata), .rdData(rdData), .rdValid(rdValid),
    .shutdownReq(shutdownReq), .rebootReq(rebootReq)
  );

  function automatic logic [31:0] cmd(input bit go, input bit wr, input int chan,
                                      input int fn, input int site, input int pos,
                                      input int dev);
    cmd = {go, wr, 4'(chan), 6'(fn), 2'b00, 2'(site), 4'(pos), 12'(dev)};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  // monitor: pops expected items as read results appear
  always @(negedge clk) begin
    if (shutdownReq) shutCnt++;
    if (rebootReq)   rebootCnt++;
    if (rdValid) begin
      if (expQ.size() == 0) begin
        check("scoreboard empty", rdData, 32'hx);
      end else begin
        string t;
        logic [31:0] e;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, rdData, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  localparam logic [7:0] A_DATA = 8'hA0;
  localparam logic [7:0] A_CTRL = 8'hA4;
  localparam logic [7:0] A_STAT = 8'hA8;

  initial begin
    logic [31:0] mb [6];
    mb[0] = 32'd50000000; mb[1] = 32'd23750000;
    for (int i = 2; i < 6; i++) mb[i] = 32'd24000000;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(A_DATA, 0, "R1 data after reset");
    rd(A_CTRL, 0, "R1 ctrl after reset");
    rd(A_STAT, 0, "R1 status after reset");

    // R12 other offsets
    rd(8'h00, 0, "R12 unmapped read");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(A_DATA, 0, "R12 unmapped write ignored");
    rd(A_STAT, 0, "R12 status untouched");

    // R2 masking, R3 no go no status
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, 32'h7FF3_FFFF, "R2 ctrl masked readback");
    rd(A_STAT, 0, "R3 no go keeps status");

    // R5 main board reads, R1 reset table values, R8 capture
    for (int d = 0; d < 6; d++) begin
      wr(A_CTRL, cmd(1, 0, 0, 1, 0, 0, d));
      rd(A_DATA, mb[d], "R1 R5 main osc read");
      rd(A_STAT, 1, "R3 status complete");
    end
    rd(A_CTRL, cmd(0, 0, 0, 1, 0, 0, 5), "R2 go bit not stored");

    wr(A_CTRL, cmd(1, 0, 0, 1, 0, 0, 6));
    rd(A_STAT, 3, "R5 main dev 6 fails");
    rd(A_DATA, mb[5], "R8 failed read keeps data");

    // R11 status write
    wr(A_STAT, 32'hFFFF_FFFC);
    rd(A_STAT, 0, "R11 upper bits dropped");
    wr(A_STAT, 32'h0000_0006);
    rd(A_STAT, 2, "R11 bits 1:0 stored");
    wr(A_STAT, 0);

    // R6 main write then read back
    wr(A_DATA, 32'h1234_5678);
    wr(A_CTRL, cmd(1, 1, 0, 1, 0, 0, 2));
    rd(A_STAT, 1, "R6 main osc write ok");
    wr(A_DATA, 0);
    wr(A_CTRL, cmd(1, 0, 0, 1, 0, 0, 2));
    rd(A_DATA, 32'h1234_5678, "R6 main osc written value");

    // R1 R6 daughter entries
    wr(A_CTRL, cmd(1, 0, 0, 1, 1, 0, 0));
    rd(A_DATA, 32'd25000000, "R1 daughter entry 0");
    wr(A_CTRL, cmd(1, 0, 0, 1, 1, 0, 1));
    rd(A_DATA, 32'd30000000, "R1 daughter entry 1");
    wr(A_CTRL, cmd(1, 0, 0, 1, 1, 0, 2));
    rd(A_STAT, 3, "R6 daughter dev at count fails");
    rd(A_DATA, 32'd30000000, "R8 data kept");
    wr(A_DATA, 32'h0000_CAFE);
    wr(A_CTRL, cmd(1, 1, 0, 1, 1, 0, 1));
    rd(A_STAT, 1, "R6 daughter write ok");
    wr(A_DATA, 0);
    wr(A_CTRL, cmd(1, 0, 0, 1, 1, 0, 1));
    rd(A_DATA, 32'h0000_CAFE, "R6 daughter written value");

    // R7 voltage
    wr(A_CTRL, cmd(1, 0, 0, 2, 0, 0, 0));
    rd(A_DATA, 32'd3300000, "R7 main voltage");
    rd(A_STAT, 1, "R7 main voltage ok");
    wr(A_CTRL, cmd(1, 0, 0, 2, 0, 0, 1));
    rd(A_STAT, 3, "R7 main voltage dev 1 fails");
    rd(A_DATA, 32'd3300000, "R8 data kept after voltage fail");
    wr(A_CTRL, cmd(1, 0, 0, 2, 1, 0, 0));
    rd(A_DATA, 32'd900000, "R7 daughter sensor 0");
    wr(A_CTRL, cmd(1, 0, 0, 2, 1, 0, 1));
    rd(A_DATA, 32'd1000000, "R7 daughter sensor 1");
    wr(A_CTRL, cmd(1, 0, 0, 2, 1, 0, 2));
    rd(A_STAT, 3, "R7 daughter sensor at count fails");
    wr(A_CTRL, cmd(1, 1, 0, 2, 0, 0, 0));
    rd(A_STAT, 3, "R7 voltage write fails");

    // R4 target legality
    wr(A_DATA, 32'h55);
    wr(A_CTRL, cmd(1, 0, 1, 1, 0, 0, 0));
    rd(A_STAT, 3, "R4 channel nonzero fails");
    rd(A_DATA, 32'h55, "R4 data kept channel");
    wr(A_CTRL, cmd(1, 0, 0, 1, 0, 1, 0));
    rd(A_STAT, 3, "R4 position nonzero fails");
    wr(A_CTRL, cmd(1, 0, 0, 1, 2, 0, 0));
    rd(A_STAT, 3, "R4 site 2 fails");
    rd(A_DATA, 32'h55, "R4 data kept site");
    wr(A_CTRL, cmd(1, 1, 0, 1, 3, 0, 0));
    rd(A_STAT, 3, "R4 site 3 write fails");
    wr(A_CTRL, cmd(1, 0, 0, 1, 0, 0, 0));
    rd(A_DATA, mb[0], "R4 table untouched by failed write");

    // R9 requests
    wr(A_CTRL, cmd(1, 1, 0, 8, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R9 shutdown pulse count", 32'(shutCnt), 1);
    check("R9 no reboot on shutdown", 32'(rebootCnt), 0);
    rd(A_STAT, 1, "R9 shutdown ok");
    wr(A_CTRL, cmd(1, 1, 0, 9, 0, 0, 0));
    repeat (3) @(negedge clk);
    check("R9 reboot pulse count", 32'(rebootCnt), 1);
    check("R9 shutdown count unchanged", 32'(shutCnt), 1);
    wr(A_CTRL, cmd(1, 0, 0, 8, 0, 0, 0));
    rd(A_STAT, 3, "R9 shutdown read fails");
    wr(A_CTRL, cmd(1, 1, 0, 9, 0, 0, 1));
    rd(A_STAT, 3, "R9 reboot dev 1 fails");
    repeat (3) @(negedge clk);
    check("R9 no stray shutdown", 32'(shutCnt), 1);
    check("R9 no stray reboot", 32'(rebootCnt), 1);

    // R10 accepted no-ops
    wr(A_CTRL, cmd(1, 1, 0, 7, 0, 0, 0));
    rd(A_STAT, 1, "R10 function 7 ok");
    wr(A_CTRL, cmd(1, 1, 0, 11, 0, 0, 0));
    rd(A_STAT, 1, "R10 function 11 ok");
    rd(A_DATA, mb[0], "R10 no-op keeps data");
    wr(A_CTRL, cmd(1, 1, 0, 3, 0, 0, 0));
    rd(A_STAT, 3, "R10 function 3 fails");
    wr(A_CTRL, cmd(1, 1, 0, 7, 1, 0, 0));
    rd(A_STAT, 3, "R10 function 7 site 1 fails");
    wr(A_CTRL, cmd(1, 0, 0, 11, 0, 0, 0));
    rd(A_STAT, 3, "R10 function 11 read fails");

    repeat (4) @(negedge clk);
    check("scoreboard drained", 32'(expQ.size()), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule